// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a serial successive-approximation converter. A one-cycle `start` pulse begins a frame. The block pulls the active-low chip-select down and drives a serial clock at a fixed fraction of the system clock. It samples the converter's data line each time it drives that clock from low to high.

The converter needs a sampling interval of five serial clocks. It then sends a single null bit, which must be zero, followed by the sixteen result bits with the most significant bit first. The block ignores the sampling window and checks the null bit. It assembles the result, then presents it on `word` together with a one-cycle `word_valid` strobe.

When `verify_en` is high at the start, chip-select stays low for a longer frame. During that frame the converter repeats the result with the least significant bit first. The block compares each repeated bit against the stored word. The repeat omits bit 0, which both passes share. Any disagreement, or a null bit of one, sets a sticky `err` flag that clears on the next accepted start. At the end of every frame chip-select rises, which sends the converter into power-down.

The control state machine has three states:

- IDLE: chip-select is high and the clock is parked low.
- SETUP: one cycle with chip-select low and the clock still low.
- SHIFT: the serial clock runs.

It has three transitions:

- **begin** (IDLE to SETUP): taken when `start` is high in IDLE.
- **launch** (SETUP to SHIFT): taken unconditionally.
- **close** (SHIFT to IDLE): taken on the falling serial-clock edge that follows the last rising edge of the frame.

Top module: `adc_frame_reader`

## Requirements
- R1: During and straight after reset, `cs_n` is 1, `sclk` is 0, `word_valid` is 0, `err` is 0 and `word` is 0.
- R2: A `start` seen high in IDLE drives `cs_n` low in the next cycle (begin). A `start` seen while a frame is running has no effect on that frame's timing or flags.
- R3: `sclk` is 0 whenever `cs_n` is 1 and during SETUP. In SHIFT it spends DIV cycles low, then DIV cycles high, and repeats, so the first rising edge comes DIV+1 cycles after `cs_n` falls.
- R4: Rising edges are numbered from 1. The bit sampled at rising edge 6 is the null bit. The bits sampled at edges 7 to 22 form `word` from bit 15 down to bit 0.
- R5: `word_valid` is high for exactly one cycle, the cycle after rising edge 22. `word` takes its new value in that cycle and holds it until the next such strobe.
- R6: Without verify the frame has FRAME_LEN rising edges (default 24). `cs_n` returns to 1, with `sclk` 0, in the cycle after the falling edge that follows the last rising edge.
- R7: `verify_en` is sampled only when a start is accepted. A verify frame has VERIFY_LEN rising edges (default 37). Edges 23 to 37 carry word bits 1 to 15 in that order.
- R8: A null bit of 1 sets `err` in the cycle after rising edge 6. `err` stays set until the next accepted start clears it.
- R9: In a verify frame, any bit at edges 23 to 37 that differs from the stored word sets `err` in the cycle after edge 37. In a frame without verify, data after edge 22 never affects `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start-of-frame request, acted on only in IDLE |
| verify_en | input | 1 | Selects the longer frame with second-pass comparison |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip-select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| word_valid | output | 1 | One-cycle strobe marking a new result |
| word | output | WORD_W | Last assembled result |
| err | output | 1 | Sticky null-bit or cross-check error flag |

## Verification
The assertions assume the converter changes `sdata` only after a falling serial-clock edge, so the line is stable at every rising edge. They also assume `start` is a synchronous pulse. The stimulus behaves that way because the bench's converter model advances its bit pointer only on falling `sclk`.

The frame contents stay fixed until `cs_n` rises again: the word, the null-bit value and the index of any corrupted repeat bit. The bench still toggles `verify_en` and pulses `start` in the middle of some frames. This shows that neither one takes effect before the next accepted start.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_t;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);

    localparam int CW = $clog2(DIV + 1) + 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          sclk_q;
    logic          tick;

    assign tick = run && (cnt == LAST);
    assign rise = tick && !sclk_q;
    assign fall = tick && sclk_q;
    assign sclk = sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt    <= cnt + CW'(1);
        end
    end

    // R3
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(cnt) != LAST) |-> $stable(sclk_q));

endmodule

// File: rtl/adc_word_capture.sv
module adc_word_capture #(
    parameter int WORD_W    = 16,
    parameter int EW        = 7,
    parameter int NULL_EDGE = 6,
    parameter int LSB_EDGE  = 22,
    parameter int VER_LAST  = 37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rise,
    input  logic [EW-1:0]     edge_no,
    input  logic              sdata,
    input  logic              verify,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              err
);

    localparam int IW = $clog2(WORD_W);
    localparam logic [EW-1:0] E_NULL = EW'(NULL_EDGE);
    localparam logic [EW-1:0] E_MSB  = EW'(NULL_EDGE + 1);
    localparam logic [EW-1:0] E_LSB  = EW'(LSB_EDGE);
    localparam logic [EW-1:0] E_VLST = EW'(VER_LAST);

    logic [WORD_W-1:0] sh;
    logic              mm_acc;
    logic [EW-1:0]     vofs;
    logic              in_data;
    logic              in_ver;
    logic              miss;

    assign vofs    = edge_no - E_LSB;
    assign in_data = (edge_no >= E_MSB) && (edge_no <= E_LSB);
    assign in_ver  = verify && (edge_no > E_LSB) && (edge_no <= E_VLST);
    assign miss    = in_ver && (sdata != word[vofs[IW-1:0]]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            word   <= '0;
            valid  <= 1'b0;
            err    <= 1'b0;
            mm_acc <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (clear) begin
                err    <= 1'b0;
                mm_acc <= 1'b0;
            end else if (rise) begin
                if (edge_no == E_NULL && sdata) begin
                    err <= 1'b1;
                end
                if (in_data) begin
                    sh <= {sh[WORD_W-2:0], sdata};
                end
                if (edge_no == E_LSB) begin
                    word  <= {sh[WORD_W-2:0], sdata};
                    valid <= 1'b1;
                end
                if (miss) begin
                    mm_acc <= 1'b1;
                end
                if (in_ver && edge_no == E_VLST && (mm_acc || miss)) begin
                    err <= 1'b1;
                end
            end
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(word));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int WORD_W     = 16,
    parameter int SMPL_EDGES = 5,
    parameter int FRAME_LEN  = 24,
    parameter int VERIFY_LEN = 37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              verify_en,
    input  logic              sdata,
    output logic              cs_n,
    output logic              sclk,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic              err
);

    localparam int NULL_EDGE = SMPL_EDGES + 1;
    localparam int LSB_EDGE  = NULL_EDGE + WORD_W;
    localparam int VER_LAST  = LSB_EDGE + WORD_W - 1;
    localparam int MAX_LEN   = (VERIFY_LEN > FRAME_LEN) ? VERIFY_LEN : FRAME_LEN;
    localparam int EW        = $clog2(MAX_LEN + 1) + 1;
    localparam logic [EW-1:0] LEN_N = EW'(FRAME_LEN);
    localparam logic [EW-1:0] LEN_V = EW'(VERIFY_LEN);

    rd_state_t     st, st_nxt;
    logic          vmode;
    logic [EW-1:0] edge_cnt;
    logic [EW-1:0] last_e;
    logic          accept;
    logic          run;
    logic          rise, fall;

    assign accept = (st == ST_IDLE) && start;
    assign last_e = vmode ? LEN_V : LEN_N;

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (start) st_nxt = ST_SETUP;
            ST_SETUP: st_nxt = ST_SHIFT;
            ST_SHIFT: if (fall && edge_cnt == last_e) st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // frame bookkeeping latched at begin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vmode    <= 1'b0;
            edge_cnt <= '0;
        end else if (accept) begin
            vmode    <= verify_en;
            edge_cnt <= '0;
        end else if (rise) begin
            edge_cnt <= edge_cnt + EW'(1);
        end
    end

    // outputs decoded from state
    always_comb begin
        cs_n = 1'b1;
        run  = 1'b0;
        unique case (st)
            ST_IDLE:  cs_n = 1'b1;
            ST_SETUP: cs_n = 1'b0;
            ST_SHIFT: begin cs_n = 1'b0; run = 1'b1; end
            default:  cs_n = 1'b1;
        endcase
    end

    adc_sclk_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    adc_word_capture #(
        .WORD_W    (WORD_W),
        .EW        (EW),
        .NULL_EDGE (NULL_EDGE),
        .LSB_EDGE  (LSB_EDGE),
        .VER_LAST  (VER_LAST)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .rise    (rise),
        .edge_no (edge_cnt + EW'(1)),
        .sdata   (sdata),
        .verify  (vmode),
        .word    (word),
        .valid   (word_valid),
        .err     (err)
    );

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && start) |=> !cs_n);

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R6
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(sclk));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(cs_n && start)) |=> err);

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> $stable(vmode));

endmodule

// File: tb/adc_frame_reader_bench.sv
`timescale 1ns/1ps
module adc_frame_reader_bench;

    localparam int DIV     = 3;
    localparam int FLEN    = 24;
    localparam int VLEN    = 37;
    localparam int NULL_P  = (2*6 - 1)*DIV + 1;
    localparam int VALID_P = (2*22 - 1)*DIV + 1;
    localparam int VER_P   = (2*37 - 1)*DIV + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        verify_en = 1'b0;
    logic        sdata;
    logic        cs_n, sclk, word_valid, err;
    logic [15:0] word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // converter model state
    logic [15:0] f_word = '0;
    logic        f_null = 1'b0;
    int          f_flip = 0;
    int          nfall  = 0;

    // reference model state
    bit          m_act = 0;
    bit          m_ver = 0;
    int          m_p = 0;
    int          m_len = 0;
    logic [15:0] m_word = '0;
    logic        m_err = 1'b0;
    logic [15:0] m_fw = '0;
    logic        m_fn = 1'b0;
    int          m_ff = 0;

    always #4 clk = !clk;

    adc_frame_reader #(.DIV(DIV), .FRAME_LEN(FLEN), .VERIFY_LEN(VLEN)) u_adc_frame_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .verify_en(verify_en),
        .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .word_valid(word_valid),
        .word(word), .err(err)
    );

    function automatic logic emu_bit(int k, logic [15:0] w, logic nb, int fk);
        if (k <= 5)  return 1'b0;
        if (k == 6)  return nb;
        if (k <= 22) return w[22-k];
        if (k <= 37) return w[k-22] ^ (k == fk);
        return 1'b0;
    endfunction

    assign sdata = cs_n ? 1'b0 : emu_bit(nfall + 1, f_word, f_null, f_flip);

    always @(negedge cs_n) nfall = 0;
    always @(negedge sclk) if (!cs_n) nfall = nfall + 1;

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_err = 1'b0; m_word = '0;
        end else if (!m_act) begin
            if (start) begin
                m_act = 1; m_p = 0; m_ver = verify_en;
                m_len = verify_en ? VLEN : FLEN;
                m_err = 1'b0; m_fw = f_word; m_fn = f_null; m_ff = f_flip;
            end
        end else begin
            m_p = m_p + 1;
            if (m_p == 2*m_len*DIV + 1) m_act = 0;
            if (m_act && m_p == VALID_P) m_word = m_fw;
            if (m_act && m_p == NULL_P && m_fn) m_err = 1'b1;
            if (m_act && m_ver && m_p == VER_P && m_ff >= 23 && m_ff <= 37) m_err = 1'b1;
        end
        cycles++;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic e_cs, e_sclk, e_val;
            e_cs   = !m_act;
            e_sclk = m_act && m_p >= 1 && (((m_p - 1) / DIV) % 2 == 1);
            e_val  = m_act && m_p == VALID_P;
            chk(cs_n == e_cs, "R2 R6 R7 cs_n", cs_n, e_cs);
            chk(sclk == e_sclk, "R3 sclk", sclk, e_sclk);
            chk(word_valid == e_val, "R5 word_valid", word_valid, e_val);
            chk(word == m_word, "R4 word", word, m_word);
            chk(err == m_err, "R8 R9 err", err, m_err);
        end
    end

    task automatic run_frame(logic [15:0] w, bit ver, logic nb, int fk, bit poke);
        f_word = w; f_null = nb; f_flip = fk;
        @(negedge clk);
        verify_en = ver; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            verify_en = !ver; start = 1'b1;   // R2 ignored mid-frame, R7 not resampled
            @(negedge clk);
            start = 1'b0;
        end
        do @(negedge clk); while (m_act);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset values
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(word_valid == 1'b0, "R1 word_valid", word_valid, 0);
        chk(err == 1'b0, "R1 err", err, 0);
        chk(word == 16'h0, "R1 word", word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 idle after reset", {cs_n, sclk}, 2'b10);

        run_frame(16'h0000, 0, 1'b0, 0, 0);   // R4 all zeros
        run_frame(16'hFFFF, 0, 1'b0, 0, 0);   // R4 all ones
        run_frame(16'h8001, 0, 1'b0, 0, 0);   // R4 bit order
        for (int i = 0; i < 8; i++) run_frame(16'($urandom), 0, 1'b0, 0, 0);
        run_frame(16'h5A5A, 0, 1'b1, 0, 0);   // R8 null bit set
        chk(err == 1'b1, "R8 err after bad null", err, 1);
        run_frame(16'h1234, 0, 1'b0, 0, 0);   // R8 cleared by next start
        chk(err == 1'b0, "R8 err cleared", err, 0);
        run_frame(16'hBEEF, 0, 1'b0, 23, 0);  // R9 normal mode ignores later bits
        chk(err == 1'b0, "R9 no err in normal mode", err, 0);
        for (int i = 0; i < 5; i++) run_frame(16'($urandom), 1, 1'b0, 0, 0);  // R7
        chk(err == 1'b0, "R7 clean verify", err, 0);
        run_frame(16'hC3A5, 1, 1'b0, 23, 0);  // R9 mismatch at B1
        chk(err == 1'b1, "R9 mismatch first repeat bit", err, 1);
        run_frame(16'h0F0F, 1, 1'b0, 37, 0);  // R9 mismatch at B15
        chk(err == 1'b1, "R9 mismatch last repeat bit", err, 1);
        run_frame(16'h7E81, 1, 1'b0, 30, 0);  // R9 mid-pass
        run_frame(16'h2468, 0, 1'b0, 0, 1);   // R2 R7 mid-frame start/mode change
        run_frame(16'h1357, 1, 1'b0, 0, 1);   // R2 R7 mid-frame start/mode change
        run_frame(16'($urandom), 1, 1'b1, 0, 0); // R8 null error in verify frame

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule